// File: doc/BRIEF.md
# Load/Store Alignment and Extension Unit

This block sits between a 32-bit integer datapath and a byte-addressed data memory organised as 32-bit words. For each access it forms the byte address as a base value plus a sign-extended 16-bit displacement. It checks that address against the access size. It then drives the word address, the per-lane byte enables and the store data toward the memory. Lanes are big-endian: the byte at address 4n travels on bits 31:24.

A load is answered by the memory in the cycle after the request. The block takes the addressed byte, halfword or word out of the returned word, widens it to 32 bits with sign or zero fill, and registers the result. When an access breaks alignment, nothing goes to the memory. The block pulses an error flag for one cycle and keeps the faulting byte address in a held register. Setting the base to zero gives absolute addressing, and a zero displacement gives register-indirect addressing. Neither case needs special handling.

Top module: `lsx_unit`

## Requirements
- R1: The byte address is `req_base + sign_extend(req_off)` modulo 2^32. On an accepted access, `mem_addr` equals that address with bits 1:0 cleared.
- R2: The size code is 00 for byte, 01 for halfword, and 10 or 11 for word. A byte access is always aligned. A halfword access needs address bit 0 = 0. A word access needs address bits 1:0 = 00. An aligned request with `req_vld` high asserts `mem_req` in the same cycle.
- R3: A misaligned request keeps `mem_req`, `mem_we` and all of `mem_be` low in its cycle. It raises `err_pulse` for exactly the following cycle, and from then on `bad_addr` shows its full byte address.
- R4: `bad_addr` changes only on a misaligned request. Aligned accesses leave it untouched.
- R5: `mem_be[3]` covers bits 31:24 and `mem_be[0]` covers bits 7:0. A byte at offset o = address bits 1:0 enables only `mem_be[3-o]`. A halfword at offset o enables `mem_be[3-o]` and `mem_be[2-o]`. A word enables all four bits.
- R6: `mem_wdata` carries `req_wdata[7:0]` in all four lanes for a byte store. It carries `req_wdata[15:0]` in both halves for a halfword store, and `req_wdata` unchanged for a word store. `mem_we` is high only for an accepted store.
- R7: For a load at offset o, the byte is taken from bits (31-8o) down to (24-8o) of `mem_rdata`, and the halfword from bits (31-8o) down to (16-8o).
- R8: With `req_sgn` = 1 a loaded byte or halfword is sign-extended, and with `req_sgn` = 0 it is zero-extended. A word load is passed through unchanged.
- R9: `ld_vld` pulses in the cycle after the memory returns data, which is two edges after an accepted load request is sampled. `ld_data` changes only on that pulse. A misaligned load gives no pulse and leaves `ld_data` as it was.
- R10: After reset `mem_req`, `mem_we`, `mem_be`, `ld_vld`, `ld_data`, `err_pulse` and `bad_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Access request present this cycle |
| req_st | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code (see R2) |
| req_sgn | input | 1 | Sign-extend loaded data |
| req_base | input | 32 | Base register value |
| req_off | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store data, right-aligned |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte lane enables, big-endian |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_rdata | input | 32 | Word returned one cycle after a load request |
| ld_vld | output | 1 | Load result valid pulse |
| ld_data | output | 32 | Extended load result |
| err_pulse | output | 1 | One-cycle misalignment flag |
| bad_addr | output | 32 | Last faulting byte address |

## Verification
The assertions assume that `mem_rdata` belongs to the request sampled at the previous edge. They also assume that the size and sign inputs are held stable only while `req_vld` is high, and that reset is held across at least one edge. The bench drives each request for exactly one cycle, between falling edges. It places the reply word on `mem_rdata` in the next cycle. It sweeps every size code, every low address offset, both signedness values and both directions over three base/displacement pairs, and two of those pairs wrap around the 32-bit address space.

// File: rtl/lsx_pkg.sv
package lsx_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WALT = 2'b11
  } lsx_size_e;
endpackage

// File: rtl/lsx_agen.sv
module lsx_agen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int LANES  = 4
) (
  input  logic [ADDR_W-1:0]         base,
  input  logic [OFF_W-1:0]          off,
  input  lsx_pkg::lsx_size_e        size,
  output logic [ADDR_W-1:0]         ea,
  output logic [ADDR_W-1:0]         word_addr,
  output logic [$clog2(LANES)-1:0]  lane,
  output logic                      misalign
);
  localparam int LW = $clog2(LANES);

  function automatic logic [ADDR_W-1:0] sext_off(input logic [OFF_W-1:0] o);
    return {{(ADDR_W-OFF_W){o[OFF_W-1]}}, o};
  endfunction

  function automatic logic bad_align(input lsx_pkg::lsx_size_e s,
                                     input logic [LW-1:0] lo);
    case (s)
      lsx_pkg::SZ_BYTE: return 1'b0;
      lsx_pkg::SZ_HALF: return lo[0];
      default:          return |lo;
    endcase
  endfunction

  always_comb begin
    ea        = base + sext_off(off);
    lane      = ea[LW-1:0];
    word_addr = {ea[ADDR_W-1:LW], {LW{1'b0}}};
    misalign  = bad_align(size, lane);
  end
endmodule

// File: rtl/lsx_store_lane.sv
module lsx_store_lane #(
  parameter int DATA_W = 32
) (
  input  logic                        en,
  input  lsx_pkg::lsx_size_e          size,
  input  logic [$clog2(DATA_W/8)-1:0] lane,
  input  logic [DATA_W-1:0]           din,
  output logic [DATA_W/8-1:0]         be,
  output logic [DATA_W-1:0]           dout
);
  localparam int LANES = DATA_W / 8;

  always_comb begin
    be = '0;
    for (int i = 0; i < LANES; i++) begin
      case (size)
        lsx_pkg::SZ_BYTE: be[LANES-1-i] = en && (i == int'(lane));
        lsx_pkg::SZ_HALF: be[LANES-1-i] = en && ((i == int'(lane)) || (i == int'(lane) + 1));
        default:          be[LANES-1-i] = en;
      endcase
    end
  end

  always_comb begin
    case (size)
      lsx_pkg::SZ_BYTE: dout = {LANES{din[7:0]}};
      lsx_pkg::SZ_HALF: dout = {(LANES/2){din[15:0]}};
      default:          dout = din;
    endcase
  end
endmodule

// File: rtl/lsx_load_extract.sv
module lsx_load_extract #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]           rdata,
  input  lsx_pkg::lsx_size_e          size,
  input  logic                        sgn,
  input  logic [$clog2(DATA_W/8)-1:0] lane,
  output logic [DATA_W-1:0]           dout
);
  function automatic logic [DATA_W-1:0] widen8(input logic [7:0] b, input logic s);
    return {{(DATA_W-8){s & b[7]}}, b};
  endfunction

  function automatic logic [DATA_W-1:0] widen16(input logic [15:0] h, input logic s);
    return {{(DATA_W-16){s & h[15]}}, h};
  endfunction

  logic [DATA_W-1:0] top_aligned;

  always_comb begin
    top_aligned = rdata << {lane, 3'b000};
    case (size)
      lsx_pkg::SZ_BYTE: dout = widen8(top_aligned[DATA_W-1 -: 8], sgn);
      lsx_pkg::SZ_HALF: dout = widen16(top_aligned[DATA_W-1 -: 16], sgn);
      default:          dout = rdata;
    endcase
  end
endmodule

// File: rtl/lsx_unit.sv
module lsx_unit #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_vld,
  input  logic                 req_st,
  input  logic [1:0]           req_size,
  input  logic                 req_sgn,
  input  logic [ADDR_W-1:0]    req_base,
  input  logic [OFF_W-1:0]     req_off,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [DATA_W/8-1:0]  mem_be,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic                 ld_vld,
  output logic [DATA_W-1:0]    ld_data,
  output logic                 err_pulse,
  output logic [ADDR_W-1:0]    bad_addr
);
  localparam int LANES = DATA_W / 8;
  localparam int LW    = $clog2(LANES);

  lsx_pkg::lsx_size_e size_w;
  logic [ADDR_W-1:0]  ea_w;
  logic [LW-1:0]      lane_w;
  logic               misalign_w;
  logic               accept_w;
  logic               fault_w;
  logic [DATA_W-1:0]  ext_w;

  logic               pend_q;
  lsx_pkg::lsx_size_e pend_size_q;
  logic               pend_sgn_q;
  logic [LW-1:0]      pend_lane_q;
  logic               ld_vld_q;
  logic [DATA_W-1:0]  ld_data_q;
  logic               err_q;
  logic [ADDR_W-1:0]  bad_q;

  assign size_w = lsx_pkg::lsx_size_e'(req_size);

  lsx_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANES(LANES)) agen_i (
    .base      (req_base),
    .off       (req_off),
    .size      (size_w),
    .ea        (ea_w),
    .word_addr (mem_addr),
    .lane      (lane_w),
    .misalign  (misalign_w)
  );

  assign accept_w = req_vld && !misalign_w;
  assign fault_w  = req_vld && misalign_w;
  assign mem_req  = accept_w;
  assign mem_we   = accept_w && req_st;

  lsx_store_lane #(.DATA_W(DATA_W)) st_i (
    .en   (accept_w),
    .size (size_w),
    .lane (lane_w),
    .din  (req_wdata),
    .be   (mem_be),
    .dout (mem_wdata)
  );

  lsx_load_extract #(.DATA_W(DATA_W)) ld_i (
    .rdata (mem_rdata),
    .size  (pend_size_q),
    .sgn   (pend_sgn_q),
    .lane  (pend_lane_q),
    .dout  (ext_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_size_q <= lsx_pkg::SZ_BYTE;
      pend_sgn_q  <= 1'b0;
      pend_lane_q <= '0;
      ld_vld_q    <= 1'b0;
      ld_data_q   <= '0;
      err_q       <= 1'b0;
      bad_q       <= '0;
    end else begin
      pend_q   <= accept_w && !req_st;
      ld_vld_q <= pend_q;
      err_q    <= fault_w;
      if (accept_w && !req_st) begin
        pend_size_q <= size_w;
        pend_sgn_q  <= req_sgn;
        pend_lane_q <= lane_w;
      end
      if (pend_q)  ld_data_q <= ext_w;
      if (fault_w) bad_q     <= ea_w;
    end
  end

  assign ld_vld    = ld_vld_q;
  assign ld_data   = ld_data_q;
  assign err_pulse = err_q;
  assign bad_addr  = bad_q;
endmodule

// File: rtl/lsx_unit_chk.sv
module lsx_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_vld,
  input logic                req_st,
  input logic [1:0]          req_size,
  input logic                misalign_w,
  input logic                mem_req,
  input logic                mem_we,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic [DATA_W/8-1:0] mem_be,
  input logic                ld_vld,
  input logic [DATA_W-1:0]   ld_data,
  input logic                err_pulse,
  input logic [ADDR_W-1:0]   bad_addr
);
  a_r3_quiet_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && misalign_w) |-> (mem_be == '0 && !mem_req && !mem_we));

  a_r3_err_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && misalign_w) |=> err_pulse);

  a_r3_err_only_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (!(req_vld && misalign_w)) |=> !err_pulse);

  a_r4_bad_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !err_pulse |-> $stable(bad_addr));

  a_r1_word_aligned_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  a_r5_word_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && req_size[1]) |-> (mem_be == '1));

  a_r6_we_only_store: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_req && req_st));

  a_r9_load_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !req_st) |=> ##1 ld_vld);

  a_r9_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_vld |-> $stable(ld_data));
endmodule

bind lsx_unit lsx_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_vld    (req_vld),
  .req_st     (req_st),
  .req_size   (req_size),
  .misalign_w (misalign_w),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_be     (mem_be),
  .ld_vld     (ld_vld),
  .ld_data    (ld_data),
  .err_pulse  (err_pulse),
  .bad_addr   (bad_addr)
);

// File: tb/lsx_unit_tb_top.sv
module lsx_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0;
  logic        req_st = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic        req_sgn = 1'b0;
  logic [31:0] req_base = '0;
  logic [15:0] req_off = '0;
  logic [31:0] req_wdata = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic [31:0] mem_rdata = '0;
  logic        ld_vld;
  logic [31:0] ld_data;
  logic        err_pulse;
  logic [31:0] bad_addr;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_bad = '0;
  logic [31:0] exp_ld  = '0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  lsx_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_st(req_st),
    .req_size(req_size), .req_sgn(req_sgn), .req_base(req_base),
    .req_off(req_off), .req_wdata(req_wdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ld_vld(ld_vld),
    .ld_data(ld_data), .err_pulse(err_pulse), .bad_addr(bad_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] base, input logic [15:0] off,
                        input logic [1:0] sz, input logic sgn, input logic st,
                        input logic [31:0] wd, input logic [31:0] rword);
    logic [31:0] ea;
    logic [1:0]  o;
    logic        mis;
    logic [3:0]  ebe;
    logic [31:0] ewd;
    logic [31:0] raw;
    ea  = base + {{16{off[15]}}, off};
    o   = ea[1:0];
    mis = (sz == 2'd1 && o[0]) || (sz >= 2'd2 && o != 2'd0);
    if (sz == 2'd0)      ebe = 4'b1000 >> o;
    else if (sz == 2'd1) ebe = 4'b1100 >> o;
    else                 ebe = 4'b1111;
    if (sz == 2'd0)      ewd = wd[7:0] * 32'h0101_0101;
    else if (sz == 2'd1) ewd = wd[15:0] * 32'h0001_0001;
    else                 ewd = wd;

    @(negedge clk);
    req_vld = 1'b1; req_st = st; req_size = sz; req_sgn = sgn;
    req_base = base; req_off = off; req_wdata = wd;
    #1;
    chk("R2 mem_req", {31'd0, mem_req}, {31'd0, !mis});
    if (mis) begin
      chk("R3 be quiet", {28'd0, mem_be}, 32'd0);
      chk("R3 we quiet", {31'd0, mem_we}, 32'd0);
    end else begin
      chk("R1 mem_addr", mem_addr, ea & 32'hFFFF_FFFC);
      chk("R5 mem_be", {28'd0, mem_be}, {28'd0, ebe});
      chk("R6 mem_we", {31'd0, mem_we}, {31'd0, st});
      if (st) chk("R6 mem_wdata", mem_wdata, ewd);
    end
    @(negedge clk);
    req_vld = 1'b0;
    mem_rdata = rword;
    if (mis) exp_bad = ea;
    chk("R3 err_pulse", {31'd0, err_pulse}, {31'd0, mis});
    chk("R4 bad_addr", bad_addr, exp_bad);
    if (!mis && !st) begin
      if (sz == 2'd0) begin
        raw = (rword >> (8 * (3 - o))) & 32'hFF;
        exp_ld = (sgn && raw[7]) ? (raw | 32'hFFFF_FF00) : raw;
      end else if (sz == 2'd1) begin
        raw = (rword >> (8 * (2 - o))) & 32'hFFFF;
        exp_ld = (sgn && raw[15]) ? (raw | 32'hFFFF_0000) : raw;
      end else begin
        exp_ld = rword;
      end
    end
    @(negedge clk);
    chk("R9 ld_vld", {31'd0, ld_vld}, {31'd0, (!mis && !st)});
    chk("R7 R8 ld_data", ld_data, exp_ld);
    chk("R3 err single", {31'd0, err_pulse}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R10 mem_we", {31'd0, mem_we}, 32'd0);
    chk("R10 mem_be", {28'd0, mem_be}, 32'd0);
    chk("R10 ld_vld", {31'd0, ld_vld}, 32'd0);
    chk("R10 ld_data", ld_data, 32'd0);
    chk("R10 err_pulse", {31'd0, err_pulse}, 32'd0);
    chk("R10 bad_addr", bad_addr, 32'd0);
    rst_n = 1'b1;
    for (int p = 0; p < 3; p++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int lo = 0; lo < 4; lo++) begin
          for (int sg = 0; sg < 2; sg++) begin
            for (int st = 0; st < 2; st++) begin
              logic [31:0] b;
              logic [15:0] of;
              logic [31:0] rw;
              if (p == 0)      begin b = 32'h0000_1000; of = 16'h0020; end
              else if (p == 1) begin b = 32'hFFFF_FFF0; of = 16'h0014; end
              else             begin b = 32'h0000_0040; of = 16'hFFE0; end
              of = of + 16'(lo);
              rw = sg[0] ? 32'hF17E_8C03 : 32'h7E81_03F2;
              access(b, of, 2'(sz), sg[0], st[0],
                     32'hA5C3_96E1 ^ (32'(p * 16 + lo) << 4), rw);
            end
          end
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule